// File: doc/BRIEF.md
# Endpoint Base Address Register File

This block holds the six base address registers of a PCIe endpoint function and answers every access to them. Three sources reach the registers. The root complex uses a link-side configuration port during enumeration. Local firmware uses a primary register port to set BAR attributes. A shadow port lets local firmware set each BAR's size mask and its enable. The block applies the size masking and the per-source read-only rules. It also handles fixed-size I/O BARs and the pairing of an even BAR with the odd BAR above it into one 64-bit memory address.

Every port has a registered read path with one cycle of latency. All three read paths see the same register view. Each write port has byte lane enables. Only one write is accepted per cycle. The priority is link, then primary, then shadow. A local write that loses is held off through its ready output and must be held until it is accepted. Decoding of configuration requests, address translation and inbound address matching are left to neighbouring blocks.

Top module: `bar_regfile`

## Requirements
- R1: After reset, every BAR is enabled, memory space (bit 0 = 0), 32-bit type (bits 2:1 = 2'b00) and prefetchable (bit 3 = 1), and its base is zero, so it reads 32'h0000_0008. The size masks M are 20, 16, 20, 16, 12 and 16 bits for BAR0 to BAR5.
- R2: A link write changes only the base address bits [31:M] of a memory BAR. Bits [M-1:4] always read zero, and bits [3:0] are never changed by a link write. Writing all ones therefore reads back as the size pattern, for example 32'hFFF0_0008 for M = 20.
- R3: A primary-port write with ro_wr_en = 1 updates the writable base bits. When byte lane 0 is enabled, it also writes bit 0 (space), bits 2:1 (type) and bit 3 (prefetchable).
- R4: With ro_wr_en = 0, a primary-port write changes only the base address bits. Space, type and prefetchable stay unchanged.
- R5: A shadow-port write sets the BAR enable from bit 0 when lane 0 is enabled. For a memory BAR, each bit in [31:4] written as 1 becomes a masked size bit, and a bit written as 0 becomes a writable base bit. Shadow writes never change space, type or prefetchable.
- R6: An I/O BAR (bit 0 = 1) reads bit 0 as 1 and bits 7:1 as zero, and has a fixed 256-byte size: bits [31:8] are its base. Shadow mask writes have no effect while the BAR is I/O, so the memory mask is unchanged when the BAR returns to memory space.
- R7: When an even BAR is memory space with type 2'b10, the odd BAR above it is its upper address half. That odd BAR reads all 32 stored bits, link and primary writes may change all 32 bits, shadow writes to it have no effect, and its enable follows the even BAR.
- R8: A disabled BAR reads as 32'h0 on all three ports and ignores link writes. Primary writes to a disabled BAR still take effect and become visible once the BAR is enabled again.
- R9: Write priority is link, then primary, then shadow. pr_ready is low exactly when lk_we is high. sh_ready is low exactly when lk_we or pr_we is high. A write that is not ready has no effect in that cycle.
- R10: Read data appears on the port's rdata one cycle after its re and holds until the next read. A write in the same cycle does not change the value returned. Indexes 6 and 7 read zero, and writes to them change nothing.
- R11: A write changes only the byte lanes whose byte enable bit (bit n for data bits [8n+7:8n]) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ro_wr_en | input | 1 | Lets primary-port writes change BAR attribute bits |
| lk_we | input | 1 | Link-side write strobe |
| lk_re | input | 1 | Link-side read strobe |
| lk_idx | input | 3 | Link-side BAR index |
| lk_wdata | input | 32 | Link-side write data |
| lk_be | input | 4 | Link-side byte enables |
| lk_rdata | output | 32 | Link-side registered read data |
| pr_we | input | 1 | Primary-port write strobe |
| pr_re | input | 1 | Primary-port read strobe |
| pr_idx | input | 3 | Primary-port BAR index |
| pr_wdata | input | 32 | Primary-port write data |
| pr_be | input | 4 | Primary-port byte enables |
| pr_ready | output | 1 | Primary write accepted this cycle |
| pr_rdata | output | 32 | Primary-port registered read data |
| sh_we | input | 1 | Shadow-port write strobe |
| sh_re | input | 1 | Shadow-port read strobe |
| sh_idx | input | 3 | Shadow-port BAR index |
| sh_wdata | input | 32 | Shadow-port write data: mask bits and enable |
| sh_be | input | 4 | Shadow-port byte enables |
| sh_ready | output | 1 | Shadow write accepted this cycle |
| sh_rdata | output | 32 | Shadow-port registered read data |

## Verification
The properties take the write strobes and ro_wr_en to be known, non-X values on each clock edge after reset. They also assume that ro_wr_en is meant to apply in the same cycle as the primary write it governs. The stimulus sets every input at the falling edge and holds it through the rising edge. It releases reset only after several cycles of idle inputs. In the collision tests, each stalled local write is held until its ready is seen, as the port protocol requires. In the random phase, strobes may change every cycle; the properties still hold because they only relate strobes to ready and to attribute stability.

// File: rtl/bar_pkg.sv
package bar_pkg;

    localparam int DATA_W   = 32;
    localparam int LANES    = DATA_W / 8;
    localparam int LOW_ATTR = 4;
    localparam int MSK_W    = DATA_W - LOW_ATTR;
    localparam int IO_BITS  = 8;

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_LINK = 2'd1,
        WR_PRIM = 2'd2,
        WR_SHAD = 2'd3
    } wr_src_e;

    typedef struct packed {
        logic [DATA_W-1:0] addr;
        logic [MSK_W-1:0]  msk;
        logic              en;
        logic              space;
        logic [1:0]        typ;
        logic              pref;
    } bar_state_t;

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    function automatic logic [MSK_W-1:0] reset_mask(input int m);
        logic [MSK_W-1:0] r;
        for (int j = 0; j < MSK_W; j++) begin
            r[j] = ((j + LOW_ATTR) < m);
        end
        return r;
    endfunction

endpackage

// File: rtl/bar_wr_arb.sv
module bar_wr_arb
    import bar_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic              lk_we,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [DATA_W-1:0] lk_wdata,
    input  logic [LANES-1:0]  lk_be,
    input  logic              pr_we,
    input  logic [IDX_W-1:0]  pr_idx,
    input  logic [DATA_W-1:0] pr_wdata,
    input  logic [LANES-1:0]  pr_be,
    input  logic              sh_we,
    input  logic [IDX_W-1:0]  sh_idx,
    input  logic [DATA_W-1:0] sh_wdata,
    input  logic [LANES-1:0]  sh_be,
    output logic              pr_ready,
    output logic              sh_ready,
    output wr_src_e           g_src,
    output logic [IDX_W-1:0]  g_idx,
    output logic [DATA_W-1:0] g_data,
    output logic [LANES-1:0]  g_be
);

    always_comb begin
        pr_ready = !lk_we;
        sh_ready = !(lk_we || pr_we);
        g_src    = WR_NONE;
        g_idx    = '0;
        g_data   = '0;
        g_be     = '0;
        if (lk_we) begin
            g_src  = WR_LINK;
            g_idx  = lk_idx;
            g_data = lk_wdata;
            g_be   = lk_be;
        end else if (pr_we) begin
            g_src  = WR_PRIM;
            g_idx  = pr_idx;
            g_data = pr_wdata;
            g_be   = pr_be;
        end else if (sh_we) begin
            g_src  = WR_SHAD;
            g_idx  = sh_idx;
            g_data = sh_wdata;
            g_be   = sh_be;
        end
    end

endmodule

// File: rtl/bar_slot.sv
module bar_slot
    import bar_pkg::*;
#(
    parameter int RST_M = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ro_wr_en,
    input  logic              wr_hit,
    input  wr_src_e           wr_src,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic              is_upper,
    input  logic              upper_en,
    output logic [DATA_W-1:0] view,
    output logic              en_o,
    output logic              space_o,
    output logic [1:0]        typ_o,
    output logic              pref_o
);

    localparam logic [DATA_W-1:0] IO_KEEP = ~((DATA_W'(1) << IO_BITS) - DATA_W'(1));

    bar_state_t st_d, st_q;
    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] lanes;
    logic [DATA_W-1:0] new_addr;
    logic              en_eff;

    always_comb begin
        st_d  = st_q;
        lanes = lane_mask(wr_be);
        if (is_upper) begin
            wmask = '1;
        end else if (st_q.space) begin
            wmask = IO_KEEP;
        end else begin
            wmask = {~st_q.msk, {LOW_ATTR{1'b0}}};
        end
        en_eff   = is_upper ? upper_en : st_q.en;
        new_addr = (st_q.addr & ~(wmask & lanes)) | (wr_data & wmask & lanes);

        if (wr_hit) begin
            unique case (wr_src)
                WR_LINK: begin
                    if (en_eff) begin
                        st_d.addr = new_addr;
                    end
                end
                WR_PRIM: begin
                    st_d.addr = new_addr;
                    if (ro_wr_en && wr_be[0] && !is_upper) begin
                        st_d.space = wr_data[0];
                        st_d.typ   = wr_data[2:1];
                        st_d.pref  = wr_data[3];
                    end
                end
                WR_SHAD: begin
                    if (!is_upper) begin
                        if (wr_be[0]) begin
                            st_d.en = wr_data[0];
                        end
                        if (!st_q.space) begin
                            st_d.msk = (st_q.msk & ~lanes[DATA_W-1:LOW_ATTR])
                                     | (wr_data[DATA_W-1:LOW_ATTR] & lanes[DATA_W-1:LOW_ATTR]);
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.addr  <= '0;
            st_q.msk   <= reset_mask(RST_M);
            st_q.en    <= 1'b1;
            st_q.space <= 1'b0;
            st_q.typ   <= 2'b00;
            st_q.pref  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (!en_eff) begin
            view = '0;
        end else if (is_upper) begin
            view = st_q.addr;
        end else if (st_q.space) begin
            view = {st_q.addr[DATA_W-1:IO_BITS], {(IO_BITS-1){1'b0}}, 1'b1};
        end else begin
            view = {st_q.addr[DATA_W-1:LOW_ATTR] & ~st_q.msk, st_q.pref, st_q.typ, 1'b0};
        end
    end

    assign en_o    = st_q.en;
    assign space_o = st_q.space;
    assign typ_o   = st_q.typ;
    assign pref_o  = st_q.pref;

endmodule

// File: rtl/bar_rd_port.sv
module bar_rd_port
    import bar_pkg::*;
#(
    parameter int NBAR  = 6,
    parameter int IDX_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         re,
    input  logic [IDX_W-1:0]             idx,
    input  logic [NBAR-1:0][DATA_W-1:0]  views,
    output logic [DATA_W-1:0]            rdata
);

    logic [DATA_W-1:0] rd_d, rd_q;
    logic [DATA_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int k = 0; k < NBAR; k++) begin
            if (idx == IDX_W'(k)) begin
                sel = views[k];
            end
        end
        rd_d = re ? sel : rd_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/bar_regfile.sv
module bar_regfile
    import bar_pkg::*;
#(
    parameter int          NBAR = 6,
    parameter int unsigned SIZE_W [NBAR] = '{20, 16, 20, 16, 12, 16},
    localparam int         IDX_W = (NBAR > 1) ? $clog2(NBAR + 2) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ro_wr_en,
    input  logic              lk_we,
    input  logic              lk_re,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [31:0]       lk_wdata,
    input  logic [3:0]        lk_be,
    output logic [31:0]       lk_rdata,
    input  logic              pr_we,
    input  logic              pr_re,
    input  logic [IDX_W-1:0]  pr_idx,
    input  logic [31:0]       pr_wdata,
    input  logic [3:0]        pr_be,
    output logic              pr_ready,
    output logic [31:0]       pr_rdata,
    input  logic              sh_we,
    input  logic              sh_re,
    input  logic [IDX_W-1:0]  sh_idx,
    input  logic [31:0]       sh_wdata,
    input  logic [3:0]        sh_be,
    output logic              sh_ready,
    output logic [31:0]       sh_rdata
);

    wr_src_e                    g_src;
    logic [IDX_W-1:0]           g_idx;
    logic [DATA_W-1:0]          g_data;
    logic [LANES-1:0]           g_be;
    logic [NBAR-1:0][DATA_W-1:0] views;
    logic [NBAR-1:0]            en_vec;
    logic [NBAR-1:0]            sp_vec;
    logic [NBAR-1:0]            pf_vec;
    logic [NBAR-1:0][1:0]       ty_vec;
    logic [NBAR*4-1:0]          attr_vec;

    bar_wr_arb #(.IDX_W(IDX_W)) u_arb (
        .lk_we    (lk_we),
        .lk_idx   (lk_idx),
        .lk_wdata (lk_wdata),
        .lk_be    (lk_be),
        .pr_we    (pr_we),
        .pr_idx   (pr_idx),
        .pr_wdata (pr_wdata),
        .pr_be    (pr_be),
        .sh_we    (sh_we),
        .sh_idx   (sh_idx),
        .sh_wdata (sh_wdata),
        .sh_be    (sh_be),
        .pr_ready (pr_ready),
        .sh_ready (sh_ready),
        .g_src    (g_src),
        .g_idx    (g_idx),
        .g_data   (g_data),
        .g_be     (g_be)
    );

    for (genvar k = 0; k < NBAR; k++) begin : g_bar
        logic is_upper;
        logic upper_en;

        if ((k % 2) == 1) begin : g_odd
            assign is_upper = !sp_vec[k-1] && (ty_vec[k-1] == 2'b10);
            assign upper_en = en_vec[k-1];
        end else begin : g_even
            assign is_upper = 1'b0;
            assign upper_en = 1'b0;
        end

        bar_slot #(.RST_M(int'(SIZE_W[k]))) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .ro_wr_en (ro_wr_en),
            .wr_hit   (g_idx == IDX_W'(k)),
            .wr_src   (g_src),
            .wr_data  (g_data),
            .wr_be    (g_be),
            .is_upper (is_upper),
            .upper_en (upper_en),
            .view     (views[k]),
            .en_o     (en_vec[k]),
            .space_o  (sp_vec[k]),
            .typ_o    (ty_vec[k]),
            .pref_o   (pf_vec[k])
        );

        assign attr_vec[k*4 +: 4] = {pf_vec[k], ty_vec[k], sp_vec[k]};
    end

    bar_rd_port #(.NBAR(NBAR), .IDX_W(IDX_W)) u_rd_lk (
        .clk (clk), .rst_n (rst_n), .re (lk_re), .idx (lk_idx),
        .views (views), .rdata (lk_rdata)
    );

    bar_rd_port #(.NBAR(NBAR), .IDX_W(IDX_W)) u_rd_pr (
        .clk (clk), .rst_n (rst_n), .re (pr_re), .idx (pr_idx),
        .views (views), .rdata (pr_rdata)
    );

    bar_rd_port #(.NBAR(NBAR), .IDX_W(IDX_W)) u_rd_sh (
        .clk (clk), .rst_n (rst_n), .re (sh_re), .idx (sh_idx),
        .views (views), .rdata (sh_rdata)
    );

endmodule

// File: rtl/bar_regfile_chk.sv
module bar_regfile_chk #(
    parameter int NBAR = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ro_wr_en,
    input logic              lk_we,
    input logic              pr_we,
    input logic              pr_ready,
    input logic              sh_we,
    input logic              sh_ready,
    input logic [NBAR*4-1:0] attr_vec,
    input logic [NBAR-1:0]   en_vec
);

    // R9
    lk_stalls_pr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_we |-> !pr_ready);

    // R9
    pr_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_we |-> pr_ready);

    // R9
    local_stalls_sh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_we || pr_we) |-> !sh_ready);

    // R2
    link_attr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_we |=> ($stable(attr_vec) && $stable(en_vec)));

    // R4
    ro_attr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pr_we && pr_ready && ro_wr_en) |=> $stable(attr_vec));

    // R5
    shadow_only_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_we && sh_ready) |=> $stable(en_vec));

endmodule

bind bar_regfile bar_regfile_chk #(.NBAR(NBAR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ro_wr_en (ro_wr_en),
    .lk_we    (lk_we),
    .pr_we    (pr_we),
    .pr_ready (pr_ready),
    .sh_we    (sh_we),
    .sh_ready (sh_ready),
    .attr_vec (attr_vec),
    .en_vec   (en_vec)
);

// File: tb/sim_bar_regfile.sv
module sim_bar_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ro_wr_en = 1'b1;
    logic        lk_we = 0, lk_re = 0, pr_we = 0, pr_re = 0, sh_we = 0, sh_re = 0;
    logic [2:0]  lk_idx = 0, pr_idx = 0, sh_idx = 0;
    logic [31:0] lk_wdata = 0, pr_wdata = 0, sh_wdata = 0;
    logic [3:0]  lk_be = 0, pr_be = 0, sh_be = 0;
    logic [31:0] lk_rdata, pr_rdata, sh_rdata;
    logic        pr_ready, sh_ready;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    int    widths [NB] = '{20, 16, 20, 16, 12, 16};

    always #(CLK_PERIOD/2) clk = ~clk;

    bar_regfile u0 (
        .clk(clk), .rst_n(rst_n), .ro_wr_en(ro_wr_en),
        .lk_we(lk_we), .lk_re(lk_re), .lk_idx(lk_idx), .lk_wdata(lk_wdata), .lk_be(lk_be), .lk_rdata(lk_rdata),
        .pr_we(pr_we), .pr_re(pr_re), .pr_idx(pr_idx), .pr_wdata(pr_wdata), .pr_be(pr_be),
        .pr_ready(pr_ready), .pr_rdata(pr_rdata),
        .sh_we(sh_we), .sh_re(sh_re), .sh_idx(sh_idx), .sh_wdata(sh_wdata), .sh_be(sh_be),
        .sh_ready(sh_ready), .sh_rdata(sh_rdata)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [31:0] m_addr [NB];
    logic [31:0] m_msk  [NB];
    logic        m_en   [NB];
    logic        m_sp   [NB];
    logic        m_pf   [NB];
    logic [1:0]  m_ty   [NB];
    logic [31:0] e_lk = 0, e_pr = 0, e_sh = 0;
    logic [31:0] n_lk, n_pr, n_sh;

    function automatic bit m_upper(int k);
        if (k % 2 == 0) return 0;
        return (m_sp[k-1] == 1'b0) && (m_ty[k-1] == 2'b10);
    endfunction

    function automatic bit m_on(int k);
        return m_upper(k) ? m_en[k-1] : m_en[k];
    endfunction

    function automatic logic [31:0] m_view(int k);
        if (k >= NB) return 32'h0;
        if (!m_on(k)) return 32'h0;
        if (m_upper(k)) return m_addr[k];
        if (m_sp[k]) return {m_addr[k][31:8], 8'h01};
        return (m_addr[k] & ~m_msk[k] & 32'hFFFF_FFF0) | {28'h0, m_pf[k], m_ty[k], 1'b0};
    endfunction

    function automatic logic [31:0] m_lanes(logic [3:0] be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = be[i] ? 8'hFF : 8'h00;
        return r;
    endfunction

    task automatic m_write(int src, int k, logic [31:0] d, logic [3:0] be);
        logic [31:0] wm, ln;
        if (k >= NB) return;
        ln = m_lanes(be);
        if (m_upper(k)) wm = 32'hFFFF_FFFF;
        else if (m_sp[k]) wm = 32'hFFFF_FF00;
        else wm = ~m_msk[k] & 32'hFFFF_FFF0;
        if (src == 0) begin
            if (m_on(k)) m_addr[k] = (m_addr[k] & ~(wm & ln)) | (d & wm & ln);
        end else if (src == 1) begin
            m_addr[k] = (m_addr[k] & ~(wm & ln)) | (d & wm & ln);
            if (ro_wr_en && be[0] && !m_upper(k)) begin
                m_sp[k] = d[0];
                m_ty[k] = d[2:1];
                m_pf[k] = d[3];
            end
        end else begin
            if (!m_upper(k)) begin
                if (be[0]) m_en[k] = d[0];
                if (!m_sp[k])
                    m_msk[k] = (m_msk[k] & ~(ln & 32'hFFFF_FFF0)) | (d & ln & 32'hFFFF_FFF0);
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NB; k++) begin
                m_addr[k] = 0;
                m_msk[k]  = 0;
                for (int b = 4; b < 32; b++) m_msk[k][b] = (b < widths[k]);
                m_en[k] = 1; m_sp[k] = 0; m_ty[k] = 0; m_pf[k] = 1;
            end
            e_lk = 0; e_pr = 0; e_sh = 0;
        end else begin
            check("R9", {31'h0, pr_ready}, {31'h0, !lk_we}, "pr_ready");
            check("R9", {31'h0, sh_ready}, {31'h0, !(lk_we || pr_we)}, "sh_ready");
            n_lk = lk_re ? m_view(lk_idx) : e_lk;
            n_pr = pr_re ? m_view(pr_idx) : e_pr;
            n_sh = sh_re ? m_view(sh_idx) : e_sh;
            if (lk_we) m_write(0, lk_idx, lk_wdata, lk_be);
            else if (pr_we) m_write(1, pr_idx, pr_wdata, pr_be);
            else if (sh_we) m_write(2, sh_idx, sh_wdata, sh_be);
            e_lk = n_lk; e_pr = n_pr; e_sh = n_sh;
        end
    end

    always @(negedge clk) begin
        check(cur_req, lk_rdata, e_lk, "model lk_rdata");
        check(cur_req, pr_rdata, e_pr, "model pr_rdata");
        check(cur_req, sh_rdata, e_sh, "model sh_rdata");
    end

    // ---------------- stimulus tasks ----------------
    task automatic lk_write(int k, logic [31:0] d, logic [3:0] be = 4'hF);
        lk_we = 1; lk_idx = k[2:0]; lk_wdata = d; lk_be = be;
        @(negedge clk);
        lk_we = 0;
    endtask

    task automatic pr_write(int k, logic [31:0] d, logic [3:0] be = 4'hF);
        pr_we = 1; pr_idx = k[2:0]; pr_wdata = d; pr_be = be;
        @(negedge clk);
        pr_we = 0;
    endtask

    task automatic sh_write(int k, logic [31:0] d, logic [3:0] be = 4'hF);
        sh_we = 1; sh_idx = k[2:0]; sh_wdata = d; sh_be = be;
        @(negedge clk);
        sh_we = 0;
    endtask

    task automatic rchk(string req, int k, logic [31:0] exp);
        lk_re = 1; pr_re = 1; sh_re = 1;
        lk_idx = k[2:0]; pr_idx = k[2:0]; sh_idx = k[2:0];
        @(negedge clk);
        lk_re = 0; pr_re = 0; sh_re = 0;
        check(req, lk_rdata, exp, $sformatf("BAR%0d lk read", k));
        check(req, pr_rdata, exp, $sformatf("BAR%0d pr read", k));
        check(req, sh_rdata, exp, $sformatf("BAR%0d sh read", k));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset values
        cur_req = "R1";
        for (int k = 0; k < NB; k++) rchk("R1", k, 32'h0000_0008);

        // R2: sizing by writing all ones over the link
        cur_req = "R2";
        for (int k = 0; k < NB; k++) begin
            lk_write(k, 32'hFFFF_FFFF);
            rchk("R2", k, ~((32'h1 << widths[k]) - 1) | 32'h8);
        end
        lk_write(1, 32'h1234_5678);
        rchk("R2", 1, 32'h1234_0008);

        // R11: byte lanes
        cur_req = "R11";
        lk_write(0, 32'hAABB_CCDD, 4'b1000);
        rchk("R11", 0, 32'hAAF0_0008);
        lk_write(0, 32'h0000_0000, 4'b0100);
        rchk("R11", 0, 32'hAA00_0008);

        // R4: attributes locked
        cur_req = "R4";
        ro_wr_en = 0;
        pr_write(2, 32'h0000_000F);
        rchk("R4", 2, 32'h0000_0008);

        // R3: attributes writable
        cur_req = "R3";
        ro_wr_en = 1;
        pr_write(2, 32'h5550_0006);
        rchk("R3", 2, 32'h5550_0006);
        pr_write(2, 32'h0000_000F, 4'b1110);
        rchk("R3", 2, 32'h0000_0006);

        // R5: shadow mask and enable
        cur_req = "R5";
        sh_write(4, 32'h0000_FFF1);
        rchk("R5", 4, 32'hFFFF_0008);
        lk_write(4, 32'h0000_0000);
        rchk("R5", 4, 32'h0000_0008);
        lk_write(4, 32'hFFFF_FFFF);
        rchk("R5", 4, 32'hFFFF_0008);

        // R8: disabled BAR
        cur_req = "R8";
        sh_write(5, 32'h0000_FFF0);
        rchk("R8", 5, 32'h0);
        lk_write(5, 32'h0);
        sh_write(5, 32'h0000_FFF1);
        rchk("R8", 5, 32'hFFFF_0008);
        sh_write(5, 32'h0000_FFF0);
        pr_write(5, 32'hABCD_0008);
        rchk("R8", 5, 32'h0);
        sh_write(5, 32'h0000_FFF1);
        rchk("R8", 5, 32'hABCD_0008);

        // R6: I/O BAR
        cur_req = "R6";
        pr_write(3, 32'h0000_0001);
        rchk("R6", 3, 32'h0000_0001);
        lk_write(3, 32'hFFFF_FFFF);
        rchk("R6", 3, 32'hFFFF_FF01);
        sh_write(3, 32'h0FFF_FFF1);
        lk_write(3, 32'h1234_5678);
        rchk("R6", 3, 32'h1234_5601);
        pr_write(3, 32'h0000_0008);
        lk_write(3, 32'hFFFF_FFFF);
        rchk("R6", 3, 32'hFFFF_0008);

        // R7: 64-bit pairing
        cur_req = "R7";
        pr_write(0, 32'h0000_0004);
        rchk("R7", 0, 32'h0000_0004);
        rchk("R7", 1, 32'h1234_0000);
        lk_write(1, 32'hDEAD_BEEF);
        rchk("R7", 1, 32'hDEAD_BEEF);
        sh_write(1, 32'h0000_00F0);
        rchk("R7", 1, 32'hDEAD_BEEF);
        sh_write(0, 32'h0000_00F0, 4'b0001);
        rchk("R7", 1, 32'h0);
        rchk("R8", 0, 32'h0);
        lk_write(1, 32'h0);
        sh_write(0, 32'h0000_00F1, 4'b0001);
        rchk("R7", 1, 32'hDEAD_BEEF);
        pr_write(0, 32'h0000_0008);
        rchk("R7", 1, 32'hDEAD_0008);

        // R9: collisions
        cur_req = "R9";
        lk_we = 1; lk_idx = 4; lk_wdata = 32'h1111_1111; lk_be = 4'hF;
        pr_we = 1; pr_idx = 4; pr_wdata = 32'h2222_2008; pr_be = 4'hF;
        #1;
        check("R9", {31'h0, pr_ready}, 32'h0, "pr_ready during link write");
        @(negedge clk);
        lk_we = 0;
        #1;
        check("R9", {31'h0, pr_ready}, 32'h1, "pr_ready after link write");
        @(negedge clk);
        pr_we = 0;
        rchk("R9", 4, 32'h2222_0008);
        pr_we = 1; pr_idx = 4; pr_wdata = 32'h3333_0008; pr_be = 4'hF;
        sh_we = 1; sh_idx = 4; sh_wdata = 32'h0000_FFF0; sh_be = 4'hF;
        #1;
        check("R9", {31'h0, sh_ready}, 32'h0, "sh_ready during primary write");
        @(negedge clk);
        pr_we = 0;
        @(negedge clk);
        sh_we = 0;
        rchk("R9", 4, 32'h0);
        sh_write(4, 32'h0000_FFF1);
        rchk("R9", 4, 32'h3333_0008);

        // R10: read timing and out-of-range index
        cur_req = "R10";
        lk_re = 1; lk_idx = 2; lk_we = 1; lk_wdata = 32'h7770_0000; lk_be = 4'hF;
        @(negedge clk);
        lk_re = 0; lk_we = 0;
        check("R10", lk_rdata, 32'h0000_0006, "read beside write returns old value");
        @(negedge clk);
        check("R10", lk_rdata, 32'h0000_0006, "rdata holds without re");
        rchk("R10", 2, 32'h7770_0006);
        lk_write(7, 32'hFFFF_FFFF);
        rchk("R10", 7, 32'h0);
        rchk("R10", 6, 32'h0);
        rchk("R10", 5, 32'hABCD_0008);

        // mixed random traffic against the model
        cur_req = "R2,R3,R5,R9,R11";
        for (int i = 0; i < 600; i++) begin
            ro_wr_en = 1'($urandom);
            lk_we = ($urandom % 4) == 0; lk_re = 1'($urandom);
            pr_we = ($urandom % 3) == 0; pr_re = 1'($urandom);
            sh_we = ($urandom % 4) == 0; sh_re = 1'($urandom);
            lk_idx = 3'($urandom); pr_idx = 3'($urandom); sh_idx = 3'($urandom);
            lk_wdata = $urandom; pr_wdata = $urandom;
            sh_wdata = $urandom | 32'h1;
            lk_be = 4'($urandom); pr_be = 4'($urandom); sh_be = 4'($urandom);
            @(negedge clk);
        end
        lk_we = 0; pr_we = 0; sh_we = 0;
        for (int k = 0; k < 8; k++) begin
            lk_re = 1; pr_re = 1; sh_re = 1;
            lk_idx = k[2:0]; pr_idx = k[2:0]; sh_idx = k[2:0];
            @(negedge clk);
        end
        lk_re = 0; pr_re = 0; sh_re = 0;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule